// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a configurable set of general-purpose pins, grouped in banks of up to 32 pins, behind a simple single-cycle register port. Each pin has its own configuration word that sets its direction and selects which input edges raise an interrupt. Each bank has words to read back the driven output values and the sampled input values. Outputs are driven high through a write-one-to-set word and low through a write-one-to-clear word, so software never has to read, modify and write them back.

Pad inputs pass through a two-flop synchronizer. The synchronized value feeds the input-status readback and the edge detector. A detected edge latches a sticky status bit, which is cleared by writing a one to it. Interrupt masks are set through one word and cleared through another. Each bank drives one interrupt line, which is high while any of its status bits is set and unmasked. Only edge triggering is available: rising, falling or both.

The bus port has no wait states. A write takes effect at the clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i` while `req_i` is high and `we_i` is low, and is zero at all other times.

Top module: `gpio_edge_bank`

## Requirements
- R1: The configuration word of pin p is at byte address 0x100 + 4*p. Bit 0 is the direction: 1 = input (`pad_oe_o` bit low), 0 = output (`pad_oe_o` bit high). Bits [4:3] hold the trigger code. Every other bit reads as 0. After reset every pin is an input with trigger code 0.
- R2: The trigger codes are 1 = rising edge, 2 = falling edge, 3 = either edge. With code 0 no edge of that pin sets its status bit.
- R3: The per-bank words are at base + 4*b for bank b. The bases are 0x00 output value, 0x20 input value, 0x40 set outputs, 0x60 clear outputs, 0x80 interrupt status, 0xA0 mask set, 0xC0 mask clear. Bit i of a bank word belongs to pin 32*b + i. An address with non-zero bits [1:0], or one outside the map, reads 0 and its writes change nothing.
- R4: Writing to the set word drives high every output whose data bit is 1 and leaves the others unchanged. The output-value word (and the set and clear words, when read) returns the output register. After reset all outputs are 0.
- R5: Writing to the clear word drives low every output whose data bit is 1 and leaves the others unchanged.
- R6: The input-value word shows the pad input after two synchronizing flops. A pad change made before clock edge k is visible after edge k+1, and can set a status bit at edge k+2.
- R7: Writing a 1 to an interrupt-status bit clears it. Data bits of 0 leave the status unchanged.
- R8: Writing a 1 to a bit of the mask-set word masks that pin. Writing a 1 to the same bit of the mask-clear word unmasks it. Reading either word returns the mask. After reset every pin is masked.
- R9: `irq_o[b]` is high exactly while bank b has a status bit that is set and unmasked. A masked edge is still recorded in the status.
- R10: If an enabled edge is detected in the same cycle as a write-one-to-clear of that status bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 11 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pad_in_i | input | NUM_BANKS*BANK_W | Pad input levels |
| pad_out_o | output | NUM_BANKS*BANK_W | Pad output levels |
| pad_oe_o | output | NUM_BANKS*BANK_W | Pad output enables |
| irq_o | output | NUM_BANKS | One interrupt line per bank |

## Verification
The edge detector is driven by a pad pattern that raises several pins together and then drops them together. Those pins are configured as rise-only, fall-only, both and off, so each status result separates one trigger code from the others. The set, clear and status-clear words are written with sparse data, which shows that zero bits leave state untouched. A write to a second bank's set word shows that banks are separated by address.

Directed sequences check four more behaviours:
- The synchronizer latency, by reading the input word one clock and then two clocks after a pad change.
- The edge-over-clear priority, by timing a status clear onto the exact cycle of detection.
- That an edge is recorded while its pin is masked.
- That a misaligned write is ignored.

// File: rtl/gpio_eb_pkg.sv
package gpio_eb_pkg;

   localparam int ADDR_W = 11;
   localparam int DATA_W = 32;

   // bank word groups, selected by address bits [7:5]
   localparam logic [2:0] GRP_OUT  = 3'd0;
   localparam logic [2:0] GRP_IN   = 3'd1;
   localparam logic [2:0] GRP_SET  = 3'd2;
   localparam logic [2:0] GRP_CLR  = 3'd3;
   localparam logic [2:0] GRP_STAT = 3'd4;
   localparam logic [2:0] GRP_MSET = 3'd5;
   localparam logic [2:0] GRP_MCLR = 3'd6;

   localparam logic [ADDR_W-1:0] CFG_BASE = 11'h100;

   // configuration word fields
   localparam int CFG_DIR_BIT = 0;
   localparam int CFG_TRG_LSB = 3;

   typedef enum logic [1:0] {
      TRG_OFF  = 2'd0,
      TRG_RISE = 2'd1,
      TRG_FALL = 2'd2,
      TRG_ANY  = 2'd3
   } trig_e;

endpackage

// File: rtl/gpio_eb_sync.sv
module gpio_eb_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_eb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_eb_decode.sv
module gpio_eb_decode
   import gpio_eb_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = 32,
   localparam int NPINS    = NUM_BANKS * BANK_W,
   localparam int BANK_IW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int PIN_IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic [ADDR_W-1:0]  addr_i,
   output logic               bank_hit_o,
   output logic [2:0]         grp_o,
   output logic [BANK_IW-1:0] bank_o,
   output logic               cfg_hit_o,
   output logic [PIN_IW-1:0]  pin_o
);

   logic              aligned;
   logic [2:0]        bank_full;
   logic [ADDR_W-1:0] cfg_off;

   always_comb begin
      aligned    = (addr_i[1:0] == 2'b00);
      bank_full  = addr_i[4:2];
      grp_o      = addr_i[7:5];
      bank_o     = bank_full[BANK_IW-1:0];
      bank_hit_o = aligned && (addr_i[10:8] == 3'd0) && (grp_o != 3'd7)
                   && ({29'd0, bank_full} < 32'(NUM_BANKS));
      cfg_off    = addr_i - CFG_BASE;
      cfg_hit_o  = aligned && (addr_i >= CFG_BASE)
                   && ({23'd0, cfg_off[ADDR_W-1:2]} < 32'(NPINS));
      pin_o      = cfg_off[2 +: PIN_IW];
   end

endmodule

// File: rtl/gpio_eb_edge_unit.sv
module gpio_eb_edge_unit #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] level_i,
   input  logic [W-1:0] rise_en_i,
   input  logic [W-1:0] fall_en_i,
   input  logic [W-1:0] stat_clr_i,
   input  logic [W-1:0] mask_set_i,
   input  logic [W-1:0] mask_clr_i,
   output logic [W-1:0] status_o,
   output logic [W-1:0] mask_o,
   output logic         irq_o
);

   logic [W-1:0] prev_q, status_q, mask_q;
   logic [W-1:0] hit;

   assign hit = (level_i & ~prev_q & rise_en_i) | (~level_i & prev_q & fall_en_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q   <= '0;
         status_q <= '0;
         mask_q   <= '1;
      end else begin
         prev_q   <= level_i;
         status_q <= (status_q & ~stat_clr_i) | hit;
         mask_q   <= (mask_q | mask_set_i) & ~mask_clr_i;
      end
   end

   assign status_o = status_q;
   assign mask_o   = mask_q;
   assign irq_o    = |(status_q & ~mask_q);

   assert_w1c_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((stat_clr_i & ~hit) != '0) |=> ((status_q & $past(stat_clr_i & ~hit)) == '0));

   assert_edge_beats_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((stat_clr_i & hit) != '0) |=>
         ((status_q & $past(stat_clr_i & hit)) == $past(stat_clr_i & hit)));

   assert_trig_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_q & ~$past(status_q) & ~$past(rise_en_i | fall_en_i)) == '0));

   assert_mask_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_set_i != '0) |=> ((mask_q & $past(mask_set_i)) == $past(mask_set_i)));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_eb_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int BANK_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int NPINS      = NUM_BANKS * BANK_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [NPINS-1:0]  pad_in_i,
   output logic [NPINS-1:0]  pad_out_o,
   output logic [NPINS-1:0]  pad_oe_o,
   output logic [NUM_BANKS-1:0] irq_o
);

   localparam int BANK_IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int PIN_IW  = (NPINS > 1) ? $clog2(NPINS) : 1;

   if (NUM_BANKS < 1 || NUM_BANKS > 8) begin : g_bad_banks
      $error("gpio_edge_bank: NUM_BANKS must be 1..8");
   end
   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_width
      $error("gpio_edge_bank: BANK_W must be 1..32");
   end

   // ---------------- address decode ----------------
   logic               bank_hit, cfg_hit;
   logic [2:0]         grp;
   logic [BANK_IW-1:0] bank_sel;
   logic [PIN_IW-1:0]  pin_sel;
   logic               wr, rd;

   gpio_eb_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
      .addr_i     (addr_i),
      .bank_hit_o (bank_hit),
      .grp_o      (grp),
      .bank_o     (bank_sel),
      .cfg_hit_o  (cfg_hit),
      .pin_o      (pin_sel)
   );

   assign wr = req_i && we_i;
   assign rd = req_i && !we_i;

   // ---------------- per-pin configuration ----------------
   logic [NPINS-1:0] is_input_q;
   trig_e            trig_q [NPINS];
   logic [NPINS-1:0] rise_en, fall_en;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            is_input_q[p] <= 1'b1;
            trig_q[p]     <= TRG_OFF;
         end else if (wr && cfg_hit && (pin_sel == PIN_IW'(p))) begin
            is_input_q[p] <= wdata_i[CFG_DIR_BIT];
            trig_q[p]     <= trig_e'(wdata_i[CFG_TRG_LSB +: 2]);
         end
      end
      assign rise_en[p] = (trig_q[p] == TRG_RISE) || (trig_q[p] == TRG_ANY);
      assign fall_en[p] = (trig_q[p] == TRG_FALL) || (trig_q[p] == TRG_ANY);
   end

   assign pad_oe_o = ~is_input_q;

   // ---------------- input synchronizer ----------------
   logic [NPINS-1:0] in_sync;

   gpio_eb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pad_in_i),
      .q_o    (in_sync)
   );

   // ---------------- per-bank outputs and interrupts ----------------
   logic [NPINS-1:0]  out_q;
   logic [BANK_W-1:0] stat_b [NUM_BANKS];
   logic [BANK_W-1:0] mask_b [NUM_BANKS];
   logic [BANK_W-1:0] wbits;

   assign wbits = wdata_i[BANK_W-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic              sel;
      logic [BANK_W-1:0] set_v, clr_v, sclr_v, mset_v, mclr_v;

      assign sel    = wr && bank_hit && (bank_sel == BANK_IW'(b));
      assign set_v  = (sel && grp == GRP_SET)  ? wbits : '0;
      assign clr_v  = (sel && grp == GRP_CLR)  ? wbits : '0;
      assign sclr_v = (sel && grp == GRP_STAT) ? wbits : '0;
      assign mset_v = (sel && grp == GRP_MSET) ? wbits : '0;
      assign mclr_v = (sel && grp == GRP_MCLR) ? wbits : '0;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) out_q[b*BANK_W +: BANK_W] <= '0;
         else         out_q[b*BANK_W +: BANK_W] <= (out_q[b*BANK_W +: BANK_W] | set_v) & ~clr_v;
      end

      gpio_eb_edge_unit #(.W(BANK_W)) u_edge (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .level_i    (in_sync[b*BANK_W +: BANK_W]),
         .rise_en_i  (rise_en[b*BANK_W +: BANK_W]),
         .fall_en_i  (fall_en[b*BANK_W +: BANK_W]),
         .stat_clr_i (sclr_v),
         .mask_set_i (mset_v),
         .mask_clr_i (mclr_v),
         .status_o   (stat_b[b]),
         .mask_o     (mask_b[b]),
         .irq_o      (irq_o[b])
      );
   end

   assign pad_out_o = out_q;

   // ---------------- read mux ----------------
   always_comb begin
      rdata_o = '0;
      if (rd && cfg_hit) begin
         rdata_o[CFG_DIR_BIT]      = is_input_q[pin_sel];
         rdata_o[CFG_TRG_LSB +: 2] = trig_q[pin_sel];
      end else if (rd && bank_hit) begin
         unique case (grp)
            GRP_OUT, GRP_SET, GRP_CLR: rdata_o[BANK_W-1:0] = out_q[bank_sel*BANK_W +: BANK_W];
            GRP_IN:                    rdata_o[BANK_W-1:0] = in_sync[bank_sel*BANK_W +: BANK_W];
            GRP_STAT:                  rdata_o[BANK_W-1:0] = stat_b[bank_sel];
            GRP_MSET, GRP_MCLR:        rdata_o[BANK_W-1:0] = mask_b[bank_sel];
            default:                   rdata_o = '0;
         endcase
      end
   end

   // ---------------- assertions ----------------
   assert_dir_output_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && cfg_hit && !wdata_i[CFG_DIR_BIT]) |=> pad_oe_o[$past(pin_sel)]);

   assert_dir_input_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && cfg_hit && wdata_i[CFG_DIR_BIT]) |=> !pad_oe_o[$past(pin_sel)]);

   assert_out_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && bank_hit && grp == GRP_SET) |=>
         ((pad_out_o[$past(bank_sel)*BANK_W +: BANK_W] & $past(wbits)) == $past(wbits)));

   assert_out_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && bank_hit && grp == GRP_CLR) |=>
         ((pad_out_o[$past(bank_sel)*BANK_W +: BANK_W] & $past(wbits)) == '0));

endmodule

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;

   localparam int NB = 2;
   localparam int NP = NB * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, we = 1'b0;
   logic [10:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe;
   logic [NB-1:0] irq;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   gpio_edge_bank #(.NUM_BANKS(NB), .BANK_W(32), .SYNC_STAGES(2)) uut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
      .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
   );

   localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_PAD = 3'd2,
                          OP_IRQ = 3'd3, OP_OE = 3'd4, OP_OUT = 3'd5;

   typedef struct packed {
      logic [2:0]  op;
      logic [7:0]  req;
      logic [10:0] addr;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 39;
   localparam vec_t TBL [NV] = '{
      '{OP_RD,  8'd4,  11'h000, 32'h0000_0000},  // R4 outputs reset low
      '{OP_RD,  8'd8,  11'h0A0, 32'hFFFF_FFFF},  // R8 masks reset set
      '{OP_RD,  8'd8,  11'h0C4, 32'hFFFF_FFFF},  // R8 bank 1 via clear word
      '{OP_RD,  8'd1,  11'h100, 32'h0000_0001},  // R1 reset input
      '{OP_OE,  8'd1,  11'h000, 32'h0000_0000},  // R1
      '{OP_WR,  8'd1,  11'h100, 32'hFFFF_FFFE},  // R1 output, both edges
      '{OP_RD,  8'd1,  11'h100, 32'h0000_0018},  // R1 unused bits read 0
      '{OP_OE,  8'd1,  11'h000, 32'h0000_0001},  // R1
      '{OP_WR,  8'd4,  11'h040, 32'h0000_00F1},  // R4
      '{OP_RD,  8'd4,  11'h000, 32'h0000_00F1},  // R4
      '{OP_OUT, 8'd4,  11'h000, 32'h0000_00F1},  // R4
      '{OP_WR,  8'd5,  11'h060, 32'h0000_0030},  // R5
      '{OP_RD,  8'd5,  11'h000, 32'h0000_00C1},  // R5
      '{OP_RD,  8'd5,  11'h060, 32'h0000_00C1},  // R5
      '{OP_WR,  8'd3,  11'h044, 32'h8000_0001},  // R3 bank 1
      '{OP_RD,  8'd3,  11'h004, 32'h8000_0001},  // R3
      '{OP_RD,  8'd3,  11'h000, 32'h0000_00C1},  // R3 bank 0 untouched
      '{OP_WR,  8'd2,  11'h104, 32'h0000_0009},  // R2 pin1 rise
      '{OP_WR,  8'd2,  11'h108, 32'h0000_0011},  // R2 pin2 fall
      '{OP_WR,  8'd2,  11'h10C, 32'h0000_0019},  // R2 pin3 both
      '{OP_WR,  8'd2,  11'h110, 32'h0000_0001},  // R2 pin4 off
      '{OP_PAD, 8'd6,  11'h000, 32'h0000_001E},  // R6
      '{OP_RD,  8'd6,  11'h020, 32'h0000_001E},  // R6
      '{OP_RD,  8'd2,  11'h080, 32'h0000_000A},  // R2 rising
      '{OP_IRQ, 8'd9,  11'h000, 32'h0000_0000},  // R9 masked
      '{OP_WR,  8'd8,  11'h0C0, 32'h0000_0002},  // R8
      '{OP_RD,  8'd8,  11'h0A0, 32'hFFFF_FFFD},  // R8
      '{OP_IRQ, 8'd9,  11'h000, 32'h0000_0001},  // R9
      '{OP_WR,  8'd7,  11'h080, 32'h0000_0002},  // R7
      '{OP_RD,  8'd7,  11'h080, 32'h0000_0008},  // R7
      '{OP_IRQ, 8'd9,  11'h000, 32'h0000_0000},  // R9
      '{OP_PAD, 8'd2,  11'h000, 32'h0000_0000},  // R2
      '{OP_RD,  8'd2,  11'h080, 32'h0000_000C},  // R2 falling
      '{OP_WR,  8'd7,  11'h080, 32'h0000_0004},  // R7
      '{OP_RD,  8'd7,  11'h080, 32'h0000_0008},  // R7 zero bits kept
      '{OP_WR,  8'd7,  11'h080, 32'hFFFF_FFFF},  // R7
      '{OP_RD,  8'd7,  11'h080, 32'h0000_0000},  // R7
      '{OP_WR,  8'd8,  11'h0A0, 32'h0000_0002},  // R8 remask
      '{OP_RD,  8'd8,  11'h0C0, 32'hFFFF_FFFF}   // R8
   };

   task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: got %h expected %h", r, act, exp);
      end
   endtask

   task automatic do_write(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic do_read(input logic [10:0] a, output logic [31:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
      req = 1'b0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // reset state (R1, R4, R9)
      #1;
      chk(9, {30'd0, irq}, 32'd0);
      chk(1, pad_oe[31:0], 32'd0);
      chk(4, pad_out[31:0], 32'd0);

      for (int i = 0; i < NV; i++) begin
         case (TBL[i].op)
            OP_WR:  do_write(TBL[i].addr, TBL[i].data);
            OP_RD:  begin do_read(TBL[i].addr, v); chk(int'(TBL[i].req), v, TBL[i].data); end
            OP_PAD: begin
               @(negedge clk);
               pad_in[31:0] = TBL[i].data;
               repeat (3) @(negedge clk);
            end
            OP_IRQ: begin @(negedge clk); #1 chk(int'(TBL[i].req), {30'd0, irq}, TBL[i].data); end
            OP_OE:  begin @(negedge clk); #1 chk(int'(TBL[i].req), pad_oe[31:0], TBL[i].data); end
            default: begin @(negedge clk); #1 chk(int'(TBL[i].req), pad_out[31:0], TBL[i].data); end
         endcase
      end

      // R6: synchronizer latency on pin5
      @(negedge clk);
      pad_in[5] = 1'b1;
      do_read(11'h020, v);
      chk(6, v, 32'h0000_0000);
      do_read(11'h020, v);
      chk(6, v, 32'h0000_0020);
      @(negedge clk);
      pad_in[5] = 1'b0;
      repeat (3) @(negedge clk);

      // R10: clear lands on the detection cycle of a pin1 rising edge
      @(negedge clk);
      pad_in[1] = 1'b1;
      @(negedge clk);
      do_write(11'h080, 32'h0000_0002);
      do_read(11'h080, v);
      chk(10, v, 32'h0000_0002);
      do_write(11'h080, 32'h0000_0002);
      do_read(11'h080, v);
      chk(7, v, 32'h0000_0000);

      // R3 / R9: bank 1 interrupt line, pin 32
      do_write(11'h180, 32'h0000_0009);
      @(negedge clk);
      pad_in[32] = 1'b1;
      repeat (3) @(negedge clk);
      do_read(11'h084, v);
      chk(3, v, 32'h0000_0001);
      @(negedge clk); #1 chk(9, {30'd0, irq}, 32'd0);
      do_write(11'h0C4, 32'h0000_0001);
      @(negedge clk); #1 chk(9, {30'd0, irq}, 32'd2);
      do_write(11'h0A4, 32'h0000_0001);
      @(negedge clk); #1 chk(9, {30'd0, irq}, 32'd0);
      do_read(11'h084, v);
      chk(9, v, 32'h0000_0001);

      // R3: misaligned write ignored, misaligned read returns 0
      do_write(11'h041, 32'h0000_00FF);
      do_read(11'h000, v);
      chk(3, v, 32'h0000_00C1);
      do_read(11'h001, v);
      chk(3, v, 32'h0000_0000);

      finish_run();
   end

endmodule